// File: doc/BRIEF.md
# Barrel shifter with carry-out

This block shifts or rotates a 32-bit operand and reports the bit that falls off the end as a carry-out. It supports five shift kinds: logical left, logical right, arithmetic right, rotate right, and rotate right through carry by one place. Each kind follows fixed rules for shift amounts that reach or pass the operand width, and for a zero amount.

A datapath feeds it an operand, a 3-bit kind code, an 8-bit unsigned shift amount, the current carry flag and a flag-write enable. The enable is the decoder's decision about whether this operation may write the flag. The block returns the shifted value, the carry-out, and a strobe that says whether the carry-out should be written back.

A parameter selects between a purely combinational path and one output register stage. The default has the register stage. With the register stage, reset clears all outputs.

Top module: `shift_carry_unit`

## Requirements
- R1: With `OUT_REG=1`, the outputs show the result for the inputs present at the previous rising clock edge. While `rst_n` is low, the outputs are held at zero.
- R2: For kinds 0 to 3 with amount 0, the result equals the operand, `carry_out` equals `carry_in`, and `carry_upd` is 0.
- R3: For kind 0 (shift left) with amount n from 1 to 32, the result is the operand shifted left by n with zeros filled in, and the carry-out is operand bit 32-n. For n above 32, the result and the carry-out are both 0.
- R4: For kind 2 (arithmetic right) with n from 1 to 31, the upper n result bits copy operand bit 31 and the carry-out is operand bit n-1. For n of 32 or more, every result bit and the carry-out equal operand bit 31.
- R5: For kind 1 (logical right) with n from 1 to 32, the upper n result bits are 0 and the carry-out is operand bit n-1. For n above 32, the result and the carry-out are both 0.
- R6: For kind 3 (rotate right), the operand rotates by n modulo 32 and the carry-out equals result bit 31. A nonzero n that is a multiple of 32 leaves the value unchanged.
- R7: For kind 4, the result is `{carry_in, operand[31:1]}` and the carry-out is operand bit 0, whatever the amount.
- R8: `carry_upd` is 1 only when `flag_en` is 1 and either the kind is 4, or the kind is 0 to 3 and the amount is nonzero.
- R9: Kind codes 5 to 7 behave like a zero-amount shift: the operand passes through, the carry passes through, and `carry_upd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| op_in | input | 32 | Operand |
| kind | input | 3 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry |
| amt | input | 8 | Unsigned shift amount |
| carry_in | input | 1 | Current carry flag |
| flag_en | input | 1 | Permission to update the flag |
| res_out | output | 32 | Shifted result |
| carry_out | output | 1 | New carry value, or `carry_in` when not shifted |
| carry_upd | output | 1 | Carry write strobe |

## Verification
Every kind code is swept over all 256 amounts. Each sweep uses four operands: one with only the end bits set, its complement, an irregular mix, and zero. This separates sign fill from zero fill and shows which bit index ends up as the carry. The operands are paired with both carry-in values, which exposes through-carry entry and zero-amount pass-through. Both enable values are applied, so the write strobe is judged separately from the data path.

// File: rtl/shift_carry_unit.sv
module shift_carry_unit #(
  parameter int W       = 32,
  parameter int AW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  op_in,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] amt,
  input  logic          carry_in,
  input  logic          flag_en,
  output logic [W-1:0]  res_out,
  output logic          carry_out,
  output logic          carry_upd
);
  localparam int LW = $clog2(W);
  localparam logic [2:0] K_LSL = 3'd0, K_LSR = 3'd1, K_ASR = 3'd2,
                         K_ROR = 3'd3, K_RRX = 3'd4;

  logic [W:0]          lsl_t, lsr_t;
  logic signed [W:0]   asr_t;
  logic [2*W-1:0]      rot_t;
  logic [W-1:0]        r_c;
  logic                c_c, u_c;

  assign lsl_t = {1'b0, op_in} << amt;
  assign lsr_t = {op_in, 1'b0} >> amt;
  assign asr_t = $signed({op_in, 1'b0}) >>> amt;
  assign rot_t = {op_in, op_in} >> amt[LW-1:0];

  always_comb begin
    r_c = op_in;
    c_c = carry_in;
    u_c = 1'b0;
    case (kind)
      K_LSL: if (amt != '0) begin r_c = lsl_t[W-1:0]; c_c = lsl_t[W]; u_c = flag_en; end
      K_LSR: if (amt != '0) begin r_c = lsr_t[W:1];   c_c = lsr_t[0]; u_c = flag_en; end
      K_ASR: if (amt != '0) begin r_c = asr_t[W:1];   c_c = asr_t[0]; u_c = flag_en; end
      K_ROR: if (amt != '0) begin r_c = rot_t[W-1:0]; c_c = rot_t[W-1]; u_c = flag_en; end
      K_RRX: begin r_c = {carry_in, op_in[W-1:1]}; c_c = op_in[0]; u_c = flag_en; end
      default: ;
    endcase
  end

  generate
    if (OUT_REG) begin : g_reg
      logic primed;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          res_out <= '0; carry_out <= 1'b0; carry_upd <= 1'b0; primed <= 1'b0;
        end else begin
          res_out <= r_c; carry_out <= c_c; carry_upd <= u_c; primed <= 1'b1;
        end
      end

      AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(kind < K_RRX && amt == '0) |->
          res_out == $past(op_in) && carry_out == $past(carry_in) && !carry_upd); // R2
      AST_NO_EN_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !$past(flag_en) |-> !carry_upd); // R8
      AST_LSR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(kind == K_LSR && amt > W) |-> res_out == '0 && !carry_out); // R5
      AST_ASR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(kind == K_ASR && amt >= W) |->
          res_out == {W{carry_out}} && carry_out == $past(op_in[W-1])); // R4
      AST_RRX_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(kind == K_RRX) |->
          res_out[W-1] == $past(carry_in) && carry_out == $past(op_in[0])); // R7
      AST_ROR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(kind == K_ROR && amt != '0) |-> carry_out == res_out[W-1]); // R6
    end else begin : g_comb
      assign res_out   = r_c;
      assign carry_out = c_c;
      assign carry_upd = u_c;

      AST_NO_EN_NO_UPD_C: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en |-> !carry_upd); // R8
      AST_RRX_ENTRY_C: assert property (@(posedge clk) disable iff (!rst_n)
        kind == K_RRX |-> res_out[W-1] == carry_in && carry_out == op_in[0]); // R7
    end
  endgenerate
endmodule

// File: tb/shift_carry_unit_bench.sv
module shift_carry_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] op_in = '0;
  logic [2:0]  kind = '0;
  logic [7:0]  amt = '0;
  logic        carry_in = 1'b0, flag_en = 1'b0;
  logic [31:0] res_out;
  logic        carry_out, carry_upd;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_carry_unit u_shift_carry_unit (
    .clk(clk), .rst_n(rst_n), .op_in(op_in), .kind(kind), .amt(amt),
    .carry_in(carry_in), .flag_en(flag_en),
    .res_out(res_out), .carry_out(carry_out), .carry_upd(carry_upd));

  task automatic model(input logic [31:0] a, input int k, input int n, input logic ci,
                       input logic en, output logic [31:0] r, output logic c,
                       output logic u, output string tag);
    r = a; c = ci; u = 1'b0;
    if (k > 4) tag = "R9";
    else if (k < 4 && n == 0) tag = "R2";
    else begin
      u = en;
      case (k)
        0: begin tag = "R3";
          for (int i = 0; i < 32; i++) r[i] = (i - n >= 0) ? a[i-n] : 1'b0;
          c = (n <= 32) ? a[32-n] : 1'b0; end
        1: begin tag = "R5";
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? a[i+n] : 1'b0;
          c = (n <= 32) ? a[n-1] : 1'b0; end
        2: begin tag = "R4";
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? a[i+n] : a[31];
          c = (n <= 32) ? a[n-1] : a[31]; end
        3: begin tag = "R6";
          for (int i = 0; i < 32; i++) r[i] = a[(i + n) % 32];
          c = r[31]; end
        default: begin tag = "R7";
          r = {ci, a[31:1]}; c = a[0]; end
      endcase
    end
  endtask

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ops [4];
    logic [31:0] er;
    logic ec, eu;
    string tag;
    ops[0] = 32'h8000_0001; ops[1] = 32'h7FFF_FFFE;
    ops[2] = 32'hA5C3_0F96; ops[3] = 32'h0000_0000;
    op_in = 32'hFFFF_FFFF; kind = 3'd4; carry_in = 1'b1; flag_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {res_out, carry_out, carry_upd}, 34'd0);   // reset state
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++)
      for (int n = 0; n < 256; n++)
        for (int o = 0; o < 4; o++)
          for (int e = 0; e < 2; e++) begin
            op_in = ops[o]; kind = 3'(k); amt = 8'(n);
            carry_in = 1'((o + n) & 1); flag_en = 1'(e);
            model(op_in, k, n, carry_in, flag_en, er, ec, eu, tag);
            @(negedge clk);                                    // R1 one-cycle latency
            check(tag, {res_out, carry_out, 1'b0}, {er, ec, 1'b0});
            check("R8", {33'd0, carry_upd}, {33'd0, eu});
          end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule